// File: doc/BRIEF.md
# Indirect Register Access Bridge

This block gives a host with a 64-bit memory-mapped register window a way to reach a narrow 32-bit register bus that sits behind it. The host never addresses the downstream registers directly. It first places a value in a staging register. It then writes a command word that holds a word address and a request bit. The bridge turns that command into exactly one downstream word transaction. The request bit stays readable as set until the transaction completes, and software polls that same bit to learn that the access is done.

Downstream, the bridge issues a request with a valid/ready handshake. The request carries the word address, a write flag and the write data. The far side finishes the access with a one-cycle acknowledge, and a read acknowledge carries the read data. Read results are kept in a result register until the next read completes. A constant capability word, set by parameters, describes the serial controller that sits behind the downstream bus.

Top module: `ind_reg_bridge`

## Requirements
- R1: After synchronous reset, `dn_req_valid` is 0, and the command register (offset 0x10), the result register (offset 0x18) and the staging register (offset 0x20) all read 0.
- R2: Offset 0x08 reads a constant capability word with these fields: bit 1 shift order (1 = LSB first), bits 7:2 transfer width, bits 13:8 chip-select count, bit 14 clock polarity, bit 15 clock phase, bits 31:22 serial clock setting, bits 47:32 peripheral ID. Every other bit reads 0, and host writes to this offset have no effect.
- R3: A host write to offset 0x20 while idle stores bits 31:0. Reading offset 0x20 returns them, with bits 63:32 read as 0.
- R4: A write to offset 0x10 while idle, with bit 8 set and bit 9 clear, raises `dn_req_valid` in the next cycle. The request has `dn_req_write`=1, `dn_req_addr` equal to command bits 7:0, and `dn_req_wdata` equal to the staging register.
- R5: A command with bit 9 set issues a read (`dn_req_write`=0). When bits 8 and 9 are both set, the command is a read only: the command register then reads bit 9 as 1 and bit 8 as 0.
- R6: `dn_req_valid` stays high, with address, write flag and data unchanged, until a cycle in which `dn_req_ready` is high. It is low in the cycle after that handshake.
- R7: The accepted request bit (bit 8 for a write, bit 9 for a read) reads as 1 from the cycle after the command until the acknowledge. It reads as 0 from the cycle after `dn_ack`, and the command register bits 7:0 keep the word address.
- R8: On a read acknowledge, the result register bits 31:0 take `dn_ack_rdata`, and bits 63:32 read as 0 (bit 32 is the debug flag and reads 0). A write acknowledge leaves the result register unchanged.
- R9: While an access is outstanding, including the cycle of its acknowledge, host writes to offsets 0x10 and 0x20 are ignored. No new request starts, and the address and staging values are kept.
- R10: Host reads of offsets other than 0x08, 0x10, 0x18 and 0x20 return 0, and host writes to offset 0x18 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| host_we | input | 1 | Host write strobe |
| host_addr | input | 6 | Host byte offset |
| host_wdata | input | 64 | Host write data |
| host_rdata | output | 64 | Host read data for `host_addr` (combinational) |
| dn_req_valid | output | 1 | Downstream request valid |
| dn_req_ready | input | 1 | Downstream request accepted |
| dn_req_addr | output | 8 | Downstream word address |
| dn_req_write | output | 1 | 1 = write, 0 = read |
| dn_req_wdata | output | 32 | Downstream write data |
| dn_ack | input | 1 | One-cycle completion strobe |
| dn_ack_rdata | input | 32 | Read data, valid with `dn_ack` |

## Verification
Two events can fall in the same cycle: the acknowledge that ends an access and a host write of a new command or new staging data. The bench provokes this by raising `dn_ack` and `host_we` at the same edge, on randomly chosen accesses. It then judges the outcome at the ports. No new request may appear, the busy bit must read clear, and the command address and staging value must still hold the values of the completed access. A fresh command issued one cycle later must then be accepted normally.

// File: rtl/ind_reg_bridge.sv
module ind_reg_bridge #(
  parameter int WA_W          = 8,
  parameter int DW            = 32,
  parameter int HA_W          = 6,
  parameter bit CAP_LSB_FIRST = 1'b0,
  parameter int CAP_XFER_BITS = 32,
  parameter int CAP_NUM_CS    = 1,
  parameter bit CAP_CPOL      = 1'b0,
  parameter bit CAP_CPHA      = 1'b0,
  parameter int CAP_SCLK      = 0,
  parameter int CAP_PERIPH_ID = 0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            host_we,
  input  logic [HA_W-1:0] host_addr,
  input  logic [63:0]     host_wdata,
  output logic [63:0]     host_rdata,
  output logic            dn_req_valid,
  input  logic            dn_req_ready,
  output logic [WA_W-1:0] dn_req_addr,
  output logic            dn_req_write,
  output logic [DW-1:0]   dn_req_wdata,
  input  logic            dn_ack,
  input  logic [DW-1:0]   dn_ack_rdata
);
  localparam logic [HA_W-1:0] OFS_CAP  = HA_W'(8'h08);
  localparam logic [HA_W-1:0] OFS_CMD  = HA_W'(8'h10);
  localparam logic [HA_W-1:0] OFS_RDAT = HA_W'(8'h18);
  localparam logic [HA_W-1:0] OFS_WDAT = HA_W'(8'h20);
  localparam int BIT_WR = 8;
  localparam int BIT_RD = 9;
  localparam logic [63:0] CAP_WORD = {16'd0, 16'(CAP_PERIPH_ID), 10'(CAP_SCLK), 6'd0,
                                      CAP_CPHA, CAP_CPOL, 6'(CAP_NUM_CS),
                                      6'(CAP_XFER_BITS), CAP_LSB_FIRST, 1'b0};

  typedef enum logic [1:0] {PH_IDLE, PH_REQ, PH_WAIT} phase_t;

  phase_t          ph_q;
  logic            wr_busy_q, rd_busy_q;
  logic [WA_W-1:0] addr_q;
  logic [DW-1:0]   wdata_q, rdata_q;

  wire idle    = (ph_q == PH_IDLE);
  wire cmd_hit = host_we && host_addr == OFS_CMD;
  wire wd_hit  = host_we && host_addr == OFS_WDAT;
  wire go_rd   = host_wdata[BIT_RD];
  wire go_wr   = host_wdata[BIT_WR] && !host_wdata[BIT_RD];
  wire done    = (ph_q == PH_WAIT) && dn_ack;

  logic unused_hi;
  assign unused_hi = ^host_wdata[63:32];

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q      <= PH_IDLE;
      wr_busy_q <= 1'b0;
      rd_busy_q <= 1'b0;
      addr_q    <= '0;
      wdata_q   <= '0;
      rdata_q   <= '0;
    end else begin
      if (idle && wd_hit) wdata_q <= host_wdata[DW-1:0];
      if (idle && cmd_hit) begin
        addr_q <= host_wdata[WA_W-1:0];
        if (go_rd || go_wr) begin
          ph_q      <= PH_REQ;
          rd_busy_q <= go_rd;
          wr_busy_q <= go_wr;
        end
      end
      if (ph_q == PH_REQ && dn_req_ready) ph_q <= PH_WAIT;
      if (done) begin
        ph_q      <= PH_IDLE;
        wr_busy_q <= 1'b0;
        rd_busy_q <= 1'b0;
        if (rd_busy_q) rdata_q <= dn_ack_rdata;
      end
    end
  end

  assign dn_req_valid = (ph_q == PH_REQ);
  assign dn_req_addr  = addr_q;
  assign dn_req_write = wr_busy_q;
  assign dn_req_wdata = wdata_q;

  always_comb begin
    case (host_addr)
      OFS_CAP:  host_rdata = CAP_WORD;
      OFS_CMD:  host_rdata = 64'({rd_busy_q, wr_busy_q}) << BIT_WR | 64'(addr_q);
      OFS_RDAT: host_rdata = 64'(rdata_q);
      OFS_WDAT: host_rdata = 64'(wdata_q);
      default:  host_rdata = '0;
    endcase
  end

  a_r1_no_req_after_reset: assert property (@(posedge clk) rst |=> !dn_req_valid);
  a_r5_one_kind: assert property (@(posedge clk) disable iff (rst) !(rd_busy_q && wr_busy_q));
  a_r6_hold_req: assert property (@(posedge clk) disable iff (rst)
    dn_req_valid && !dn_req_ready |=> dn_req_valid && $stable(dn_req_addr)
                                      && $stable(dn_req_write) && $stable(dn_req_wdata));
  a_r6_drop_req: assert property (@(posedge clk) disable iff (rst)
    dn_req_valid && dn_req_ready |=> !dn_req_valid);
  a_r7_busy_until_ack: assert property (@(posedge clk) disable iff (rst)
    (rd_busy_q || wr_busy_q) && !dn_ack |=> (rd_busy_q || wr_busy_q));
  a_r8_result_hold: assert property (@(posedge clk) disable iff (rst)
    !(dn_ack && rd_busy_q) |=> $stable(rdata_q));
  a_r9_cmd_ignored: assert property (@(posedge clk) disable iff (rst)
    (rd_busy_q || wr_busy_q) && host_we |=> $stable(addr_q) && $stable(wdata_q));
endmodule

// File: tb/ind_reg_bridge_tb_top.sv
module ind_reg_bridge_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [5:0] A_CAP = 6'h08, A_CMD = 6'h10, A_RD = 6'h18, A_WD = 6'h20;

  logic clk = 0, rst = 1;
  logic host_we = 0;
  logic [5:0] host_addr = 0;
  logic [63:0] host_wdata = 0, host_rdata;
  logic dn_req_valid, dn_req_ready = 0, dn_req_write, dn_ack = 0;
  logic [7:0] dn_req_addr;
  logic [31:0] dn_req_wdata, dn_ack_rdata = 0;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  logic [31:0] exp_rd = 0;

  ind_reg_bridge #(.CAP_LSB_FIRST(1'b1), .CAP_XFER_BITS(24), .CAP_NUM_CS(3),
                   .CAP_CPOL(1'b0), .CAP_CPHA(1'b1), .CAP_SCLK(10'h19A),
                   .CAP_PERIPH_ID(16'hBEEF)) dut_i (
    .clk(clk), .rst(rst), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .dn_req_valid(dn_req_valid), .dn_req_ready(dn_req_ready),
    .dn_req_addr(dn_req_addr), .dn_req_write(dn_req_write),
    .dn_req_wdata(dn_req_wdata), .dn_ack(dn_ack), .dn_ack_rdata(dn_ack_rdata));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [63:0] cap_expect();
    logic [63:0] v = 0;
    v[1] = 1'b1; v[7:2] = 6'd24; v[13:8] = 6'd3; v[14] = 1'b0; v[15] = 1'b1;
    v[31:22] = 10'h19A; v[47:32] = 16'hBEEF;
    return v;
  endfunction

  function automatic logic [63:0] cmd_word(bit rd, bit wr, logic [7:0] wa);
    logic [63:0] v = 0;
    v[9] = rd; v[8] = wr; v[7:0] = wa;
    return v;
  endfunction

  task automatic check(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic peek(logic [5:0] a, output logic [63:0] v);
    host_addr = a; #1; v = host_rdata;
  endtask

  task automatic poke(logic [5:0] a, logic [63:0] d);
    @(negedge clk); host_we = 1; host_addr = a; host_wdata = d;
    @(negedge clk); host_we = 0;
  endtask

  task automatic access(bit rd, bit wr, logic [7:0] wa, logic [31:0] wd,
                        logic [31:0] rv, int rdly, int adly, bit collide);
    logic [63:0] v;
    bit ew = wr && !rd;
    poke(A_WD, {32'hFFFF_FFFF, wd});
    poke(A_CMD, cmd_word(rd, wr, wa));
    check(dn_req_valid == 1, "R4 valid", 64'(dn_req_valid), 1);
    check(dn_req_write == ew, "R5 write flag", 64'(dn_req_write), 64'(ew));
    check(dn_req_addr == wa, "R4 addr", 64'(dn_req_addr), 64'(wa));
    if (ew) check(dn_req_wdata == wd, "R4 wdata", 64'(dn_req_wdata), 64'(wd));
    peek(A_CMD, v);
    check(v[9:8] == {rd, ew}, "R5 cmd busy bits", 64'(v[9:8]), 64'({rd, ew}));
    for (int i = 0; i < rdly; i++) begin
      @(negedge clk);
      check(dn_req_valid && dn_req_addr == wa && dn_req_write == ew, "R6 hold",
            {dn_req_valid, dn_req_write, dn_req_addr}, {1'b1, ew, wa});
    end
    dn_req_ready = 1;
    @(negedge clk); dn_req_ready = 0;
    check(dn_req_valid == 0, "R6 drop", 64'(dn_req_valid), 0);
    for (int i = 0; i < adly; i++) begin
      @(negedge clk);
      peek(A_CMD, v);
      check(v[9:8] != 0, "R7 busy held", 64'(v[9:8]), 64'({rd, ew}));
    end
    dn_ack = 1; dn_ack_rdata = rv;
    if (collide) begin host_we = 1; host_addr = A_CMD; host_wdata = cmd_word(0, 1, ~wa); end
    @(negedge clk); dn_ack = 0; host_we = 0;
    if (rd) exp_rd = rv;
    peek(A_CMD, v);
    check(v[9:0] == {2'b00, wa}, "R7 busy cleared, addr kept", v, 64'(wa));
    check(dn_req_valid == 0, "R9 no request after ack-cycle command", 64'(dn_req_valid), 0);
    peek(A_RD, v);
    check(v == 64'(exp_rd), "R8 result register", v, 64'(exp_rd));
    peek(A_WD, v);
    check(v == 64'(wd), "R3 staging readback", v, 64'(wd));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [63:0] v;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst = 0;
    check(dn_req_valid == 0, "R1 valid", 64'(dn_req_valid), 0);
    peek(A_CMD, v); check(v == 0, "R1 cmd", v, 0);
    peek(A_RD, v);  check(v == 0, "R1 result", v, 0);
    peek(A_WD, v);  check(v == 0, "R1 staging", v, 0);
    peek(A_CAP, v); check(v == cap_expect(), "R2 capability", v, cap_expect());
    poke(A_CAP, 64'hFFFF_FFFF_FFFF_FFFF);
    peek(A_CAP, v); check(v == cap_expect(), "R2 write ignored", v, cap_expect());
    peek(6'h00, v); check(v == 0, "R10 undecoded 0x00", v, 0);
    peek(6'h28, v); check(v == 0, "R10 undecoded 0x28", v, 0);
    poke(A_RD, 64'h1234_5678_9ABC_DEF0);
    peek(A_RD, v); check(v == 0, "R10 result write ignored", v, 0);

    access(1, 0, 8'd2, 32'h0, 32'hCAFE_0001, 0, 0, 0);
    access(0, 1, 8'd6, 32'hA5A5_5A5A, 32'hDEAD_BEEF, 2, 1, 0);
    check(exp_rd == 32'hCAFE_0001, "R8 write ack keeps result", 64'(exp_rd), 64'hCAFE_0001);
    access(1, 1, 8'd4, 32'h1111_2222, 32'h7777_8888, 1, 2, 0);
    access(1, 0, 8'd1, 32'h0, 32'h0BAD_F00D, 1, 0, 1);
    access(0, 1, 8'd3, 32'h3333_4444, 32'h0, 0, 1, 1);

    poke(A_WD, 64'(32'hAAAA_0001));
    poke(A_CMD, cmd_word(0, 1, 8'd3));
    poke(A_WD, 64'(32'hBBBB_0002));
    poke(A_CMD, cmd_word(1, 0, 8'd5));
    check(dn_req_valid && dn_req_write && dn_req_addr == 8'd3 && dn_req_wdata == 32'hAAAA_0001,
          "R9 busy writes ignored", {dn_req_write, dn_req_addr, dn_req_wdata},
          {1'b1, 8'd3, 32'hAAAA_0001});
    dn_req_ready = 1; @(negedge clk); dn_req_ready = 0;
    dn_ack = 1; @(negedge clk); dn_ack = 0;
    peek(A_WD, v); check(v == 64'(32'hAAAA_0001), "R9 staging kept", v, 64'(32'hAAAA_0001));

    for (int n = 0; n < 40; n++) begin
      bit r = $urandom_range(0, 1);
      access(r, !r || $urandom_range(0, 1), 8'($urandom_range(0, 6)), $urandom,
             $urandom, $urandom_range(0, 3), $urandom_range(0, 3), $urandom_range(0, 1));
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule